// File: doc/BRIEF.md
# Selective Variable-Period Row Refresh Scheduler

This block decides which row of a small dynamic memory array is due for refresh next, and passes it to the memory sequencer one row at a time. Each row has a countdown counter. When the counter runs out, the row is marked pending. The lowest-numbered pending row is offered on a request/acknowledge handshake, as a read-style refresh of that single row. There is no write data.

A two-bit mode input selects how rows qualify and how their periods are chosen:
- **Selective:** only rows that hold data are considered. A row is marked as holding data when a write into it is notified. Software may later unmark it.
- **Variable period:** each row reloads from its own entry in a period table. This allows rows with weaker retention to be refreshed more often.
- **Baseline:** with both mode bits clear, every row is refreshed at one common interval.

The global enable stops all scheduling when it is low.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `req_o` and `ovf_o` are low, no row is marked valid, and every period table entry holds DEF_PER (default 100).
- R2: While `en_i` is low, no new request is raised. Every counter is held at its reload value and every pending mark is cleared.
- R3: With `mode_i` = 2'b00, every row is scheduled and each reloads from the common period FIX_PER (default 200).
- R4: With `mode_i[0]` = 1, only rows marked valid are scheduled. A write strobe marks its row valid. When no row is valid, no request is raised.
- R5: With `mode_i[1]` = 1, a row reloads from its own table entry. A table write changes only that entry and takes effect at that row's next reload.
- R6: A serve loads the row's counter with its period P, and the counter then counts down one per cycle. In the cycle the counter reads zero, the row becomes pending and the counter reloads. An idle handshake raises the request on the next edge. For a lone row, the next request therefore rises P+2 cycles after the edge at which the previous one was acknowledged.
- R7: When several rows are pending, they are offered in ascending row-index order, lowest first.
- R8: Once raised, `req_o` stays high and `req_row_o` stays unchanged until `ack_i` is high at a clock edge. `req_o` then falls at that edge.
- R9: A row whose counter runs out again while it is already pending is queued only once. A single acknowledge serves it.
- R10: `ovf_o` goes high when a pending row's counter runs out again, and stays high until reset.
- R11: A clear strobe unmarks its row, so selective mode stops refreshing it. When a write and a clear name the same row in one cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global scheduling enable |
| mode_i | input | 2 | Bit 0 selective, bit 1 per-row period |
| wr_stb_i | input | 1 | Data-write notification strobe |
| wr_row_i | input | IDX_W (4) | Row written |
| clr_stb_i | input | 1 | Clear-valid strobe |
| clr_row_i | input | IDX_W (4) | Row to unmark |
| tbl_we_i | input | 1 | Period table write enable |
| tbl_row_i | input | IDX_W (4) | Table entry to write |
| tbl_per_i | input | PER_W (12) | Period value to write |
| req_o | output | 1 | Refresh request |
| req_row_o | output | IDX_W (4) | Row to refresh |
| ack_i | input | 1 | Sequencer acknowledge |
| ovf_o | output | 1 | Sticky missed-refresh flag |

## Verification
The assertions check four rules on every cycle:
- request stability and its drop after an acknowledge,
- silence while disabled,
- stickiness of the overflow flag,
- in selective mode, every newly raised request names a row that was marked valid.

The bench scenarios are needed for everything that depends on timing and history: the ascending service order, the exact refresh interval for each programmed period and for the reset default, the absence of double queueing after a missed deadline, and the precedence of write over clear.

// File: rtl/refr_pkg.sv
package refr_pkg;

  typedef enum logic [1:0] {
    RM_SWEEP  = 2'b00,
    RM_SELECT = 2'b01,
    RM_VARPER = 2'b10,
    RM_VARSEL = 2'b11
  } refr_mode_e;

  function automatic logic mode_is_sel(refr_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_is_var(refr_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/refr_row.sv
module refr_row #(
  parameter int unsigned PER_W   = 12,
  parameter int unsigned RST_CNT = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             elig_i,
  input  logic [PER_W-1:0] reload_i,
  input  logic             serve_i,
  output logic             pend_o,
  output logic             miss_o
);

  logic [PER_W-1:0] cnt_q;
  logic             pend_q;
  logic             expire;

  assign expire = elig_i && !serve_i && (cnt_q == '0);
  assign miss_o = expire && pend_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= PER_W'(RST_CNT);
      pend_q <= 1'b0;
    end else if (!elig_i || serve_i) begin
      cnt_q  <= reload_i;
      pend_q <= 1'b0;
    end else if (expire) begin
      cnt_q  <= reload_i;
      pend_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/refr_arb.sv
module refr_arb #(
  parameter int unsigned N_ROWS = 16,
  localparam int unsigned IDX_W = $clog2(N_ROWS)
) (
  input  logic [N_ROWS-1:0] pend_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    idx_o = '0;
    for (int i = N_ROWS - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |pend_i;

endmodule

// File: rtl/refr_hs.sv
module refr_hs #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [IDX_W-1:0] row_o,
  output logic             serve_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      row_o <= '0;
    end else if (req_o) begin
      if (ack_i) req_o <= 1'b0;
    end else if (en_i && any_i) begin
      req_o <= 1'b1;
      row_o <= idx_i;
    end
  end

  assign serve_o = req_o && ack_i;

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refr_pkg::*;
#(
  parameter int unsigned N_ROWS  = 16,
  parameter int unsigned PER_W   = 12,
  parameter int unsigned DEF_PER = 100,
  parameter int unsigned FIX_PER = 200,
  localparam int unsigned IDX_W  = $clog2(N_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             wr_stb_i,
  input  logic [IDX_W-1:0] wr_row_i,
  input  logic             clr_stb_i,
  input  logic [IDX_W-1:0] clr_row_i,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_row_i,
  input  logic [PER_W-1:0] tbl_per_i,
  output logic             req_o,
  output logic [IDX_W-1:0] req_row_o,
  input  logic             ack_i,
  output logic             ovf_o
);

  refr_mode_e        mode;
  logic              sel_mode, var_mode;
  logic [N_ROWS-1:0] valid_q;
  logic [PER_W-1:0]  tbl_q [N_ROWS];
  logic [N_ROWS-1:0] elig, pend, miss, serve_vec;
  logic              any_pend, serve;
  logic [IDX_W-1:0]  pick_idx;
  logic              ovf_q;

  assign mode     = refr_mode_e'(mode_i);
  assign sel_mode = mode_is_sel(mode);
  assign var_mode = mode_is_var(mode);

  for (genvar i = 0; i < N_ROWS; i++) begin : g_row
    logic             hit_wr, hit_clr;
    logic [PER_W-1:0] reload;

    assign hit_wr  = wr_stb_i  && (wr_row_i  == IDX_W'(i));
    assign hit_clr = clr_stb_i && (clr_row_i == IDX_W'(i));

    // write has priority over clear on the same row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      valid_q[i] <= 1'b0;
      else if (hit_wr)  valid_q[i] <= 1'b1;
      else if (hit_clr) valid_q[i] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        tbl_q[i] <= PER_W'(DEF_PER);
      else if (tbl_we_i && (tbl_row_i == IDX_W'(i)))
        tbl_q[i] <= tbl_per_i;
    end

    assign elig[i]      = en_i && (!sel_mode || valid_q[i]);
    assign reload       = var_mode ? tbl_q[i] : PER_W'(FIX_PER);
    assign serve_vec[i] = serve && (req_row_o == IDX_W'(i));

    refr_row #(
      .PER_W  (PER_W),
      .RST_CNT(DEF_PER)
    ) i_row (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .elig_i  (elig[i]),
      .reload_i(reload),
      .serve_i (serve_vec[i]),
      .pend_o  (pend[i]),
      .miss_o  (miss[i])
    );
  end

  refr_arb #(
    .N_ROWS(N_ROWS)
  ) i_arb (
    .pend_i(pend),
    .any_o (any_pend),
    .idx_o (pick_idx)
  );

  refr_hs #(
    .IDX_W(IDX_W)
  ) i_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .any_i  (any_pend),
    .idx_i  (pick_idx),
    .ack_i  (ack_i),
    .req_o  (req_o),
    .row_o  (req_row_o),
    .serve_o(serve)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ovf_q <= 1'b0;
    else if (|miss) ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned N_ROWS = 16,
  localparam int unsigned IDX_W = $clog2(N_ROWS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              sel_i,
  input logic              ack_i,
  input logic              req_o,
  input logic [IDX_W-1:0]  req_row_o,
  input logic              ovf_o,
  input logic [N_ROWS-1:0] valid_q
);

  logic [N_ROWS-1:0] valid_d;
  logic              sel_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_d <= '0;
      sel_d   <= 1'b0;
    end else begin
      valid_d <= valid_q;
      sel_d   <= sel_i && en_i;
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(req_row_o));

  // R8
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);

  // R2
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !req_o |=> !req_o);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R4
  sel_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) && sel_d |-> valid_d[req_row_o]);

endmodule

bind refresh_sched refresh_sched_chk #(.N_ROWS(N_ROWS)) i_refresh_sched_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .sel_i    (mode_i[0]),
  .ack_i    (ack_i),
  .req_o    (req_o),
  .req_row_o(req_row_o),
  .ovf_o    (ovf_o),
  .valid_q  (valid_q)
);

// File: tb/test_refresh_sched.sv
module test_refresh_sched;

  localparam int N_ROWS = 16;
  localparam int PER_W  = 12;
  localparam int IDX_W  = 4;

  // {row[15:12], period[11:0]}
  localparam logic [15:0] VEC [5] = '{16'h2007, 16'h901E, 16'h0003, 16'hF00C, 16'h6032};

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [1:0]       mode_i = 2'b00;
  logic             wr_stb_i = 1'b0, clr_stb_i = 1'b0, tbl_we_i = 1'b0;
  logic [IDX_W-1:0] wr_row_i = '0, clr_row_i = '0, tbl_row_i = '0;
  logic [PER_W-1:0] tbl_per_i = '0;
  logic             req_o, ack_i = 1'b0, ovf_o;
  logic [IDX_W-1:0] req_row_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5ns clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  refresh_sched i_refresh_sched (
    .clk_i, .rst_ni, .en_i, .mode_i, .wr_stb_i, .wr_row_i, .clr_stb_i, .clr_row_i,
    .tbl_we_i, .tbl_row_i, .tbl_per_i, .req_o, .req_row_o, .ack_i, .ovf_o
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wait_req(input int limit, output bit got);
    got = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk_i);
      if (req_o) begin got = 1'b1; return; end
    end
  endtask

  task automatic do_ack();
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic pulse_wr(input int r);
    wr_stb_i = 1'b1; wr_row_i = IDX_W'(r);
    @(negedge clk_i);
    wr_stb_i = 1'b0;
  endtask

  task automatic pulse_clr(input int r);
    clr_stb_i = 1'b1; clr_row_i = IDX_W'(r);
    @(negedge clk_i);
    clr_stb_i = 1'b0;
  endtask

  task automatic prog(input int r, input int p);
    tbl_we_i = 1'b1; tbl_row_i = IDX_W'(r); tbl_per_i = PER_W'(p);
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  // watch a lone row: serve once, then measure the next interval
  task automatic measure(input int r, input int p, input string rq);
    bit got;
    int t0;
    wait_req(5000, got);
    check(got && req_row_o == IDX_W'(r), rq, int'(req_row_o), r);
    do_ack();
    t0 = cyc;
    wait_req(5000, got);
    check(got && (cyc - t0) == p + 2, rq, cyc - t0, p + 2);
    check(req_row_o == IDX_W'(r), rq, int'(req_row_o), r);
    do_ack();
  endtask

  initial begin
    #(10ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit got;
    bit quiet;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!req_o, "R1", int'(req_o), 0);
    check(!ovf_o, "R1", int'(ovf_o), 0);

    // R2: disabled, nothing may be requested
    quiet = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (req_o) quiet = 1'b0;
    end
    check(quiet, "R2", int'(!quiet), 0);

    // R3 / R7: sweep mode, all rows expire together, served ascending
    mode_i = 2'b00; en_i = 1'b1;
    for (int k = 0; k < N_ROWS; k++) begin
      wait_req(400, got);
      check(got && req_row_o == IDX_W'(k), "R7", int'(req_row_o), k);
      do_ack();
    end
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);

    // R4: selective with no valid rows stays quiet
    mode_i = 2'b01; en_i = 1'b1;
    quiet = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (req_o) quiet = 1'b0;
    end
    check(quiet, "R4", int'(!quiet), 0);
    pulse_wr(5);
    measure(5, 200, "R4");

    // R11: cleared row no longer refreshed
    pulse_clr(5);
    quiet = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk_i);
      if (req_o) quiet = 1'b0;
    end
    check(quiet, "R11", int'(!quiet), 0);

    // R5 / R6: per-row periods from the table, one row at a time
    mode_i = 2'b11;
    for (int v = 0; v < 5; v++) begin
      prog(int'(VEC[v][15:12]), int'(VEC[v][11:0]));
      pulse_wr(int'(VEC[v][15:12]));
      measure(int'(VEC[v][15:12]), int'(VEC[v][11:0]), "R6");
      pulse_clr(int'(VEC[v][15:12]));
    end

    // R1: untouched entry still holds the default period
    pulse_wr(3);
    measure(3, 100, "R1");
    pulse_clr(3);
    check(!ovf_o, "R10", int'(ovf_o), 0);

    // R8 / R9 / R10: hold off the acknowledge across two expiries
    prog(4, 20);
    pulse_wr(4);
    wait_req(500, got);
    check(got && req_row_o == 4'd4, "R8", int'(req_row_o), 4);
    quiet = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      if (!req_o || req_row_o != 4'd4) quiet = 1'b0;
    end
    check(quiet, "R8", int'(!quiet), 0);
    check(ovf_o, "R10", int'(ovf_o), 1);
    do_ack();
    quiet = 1'b1;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk_i);
      if (req_o) quiet = 1'b0;
    end
    check(quiet, "R9", int'(!quiet), 0);
    check(ovf_o, "R10", int'(ovf_o), 1);
    pulse_clr(4);
    repeat (2) @(negedge clk_i);
    if (req_o) do_ack();

    // R11: write and clear to the same row in one cycle, write wins
    wr_stb_i = 1'b1; wr_row_i = 4'd7;
    clr_stb_i = 1'b1; clr_row_i = 4'd7;
    @(negedge clk_i);
    wr_stb_i = 1'b0; clr_stb_i = 1'b0;
    wait_req(400, got);
    check(got && req_row_o == 4'd7, "R11", int'(req_row_o), 7);
    do_ack();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule